// File: doc/BRIEF.md
# Fault-Tripped Waveform Output Shutdown

This block sits between a six-channel waveform source (a dead-time or timer stage) and the output pins. It conditions an external fault pin and, once a fault is accepted, drives all six pins to a programmable safe pattern. The fault pin is synchronized first. It is qualified by an enable and a polarity select. A noise filter can also be switched in: with the filter on, the fault level must be held for several clock cycles before it counts, and the fault is ignored while the clock-running indication is low.

When there is no fault, the pins carry either the six waveform inputs or one pulse-generator output. With routing on, a 2-bit selector picks one of four pulse-generator outputs and copies it to all six pins. An optional registered gate/start strobe goes to the selected pulse generator. With the gate off, routing still works, and the generator is then started elsewhere by software.

Top module: `wave_shutdown`

## Requirements
- R1: While rst_ni is low and after reset, with all controls zero: trip_o is 0, gate_o is 0 and pin_o equals wave_i.
- R2: While trip_en_i is 0, trip_o stays 0 and trip_pin_i has no effect on pin_o.
- R3: trip_pol_i = 1 makes a high level on trip_pin_i the fault level; trip_pol_i = 0 makes a low level the fault level.
- R4: With filt_en_i = 0, trip_o goes to 1 on the third rising clock edge after trip_pin_i reaches the fault level (two synchronizer flops plus one register). It goes back to 0 on the third edge after the pin leaves that level.
- R5: With filt_en_i = 1, the fault is accepted only after four consecutive synchronized samples at the fault level. trip_o rises on the sixth rising edge after the pin reaches that level.
- R6: With filt_en_i = 1, a single synchronized sample at the inactive level restarts the count from zero. Pulses of three cycles separated by one inactive cycle never set trip_o.
- R7: With filt_en_i = 1 and clk_run_i = 0, the fault pin is ignored and trip_o is 0 one edge later. Once clk_run_i returns to 1, a held fault is accepted on the fourth edge.
- R8: While trip_o is 1, pin_o equals safe_lvl_i. Otherwise it follows the selected source.
- R9: Without a trip, pin_o is wave_i when route_en_i = 0. When route_en_i = 1, every bit of pin_o equals pg_i[route_sel_i].
- R10: One edge after gate_en_i = 1, gate_o is one-hot with bit route_sel_i set. One edge after gate_en_i = 0, gate_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_en_i | input | 1 | Fault input enable |
| trip_pol_i | input | 1 | Fault level: 1 high, 0 low |
| filt_en_i | input | 1 | Noise filter select |
| clk_run_i | input | 1 | Clock-running indication |
| route_en_i | input | 1 | Route the selected pulse output to all pins |
| route_sel_i | input | 2 | Pulse generator select |
| gate_en_i | input | 1 | Drive a gate/start strobe to the selected generator |
| safe_lvl_i | input | 6 | Pin pattern forced during a fault |
| wave_i | input | 6 | Waveform inputs |
| pg_i | input | 4 | Pulse generator outputs |
| trip_pin_i | input | 1 | Raw asynchronous fault pin |
| pin_o | output | 6 | Output pins |
| trip_o | output | 1 | Accepted (filtered) fault flag |
| gate_o | output | 4 | One-hot gate/start strobe |

## Verification
Directed patterns are used first, each separating one path from the others:
- Sustained fault levels at both polarities expose the three-edge latency of the plain path.
- Four-cycle holds against three-cycle pulses with one-cycle gaps distinguish a counter that restarts from one that only pauses.
- A held fault with the clock-running indication low and then high shows that the filter is gated and that the count restarts.
- A routing sweep over all four selector values with complementary pulse patterns exposes a wrong index.

Random runs then mix fault holds of varying length with changes to enable, polarity, filter and routing. The outputs are compared each cycle against a model that counts consecutive qualified samples.

// File: rtl/ws_pkg.sv
package ws_pkg;
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } trip_pol_e;

  localparam int unsigned DEF_OUTS   = 6;
  localparam int unsigned DEF_PGS    = 4;
  localparam int unsigned DEF_SYNC   = 2;
  localparam int unsigned DEF_FILT_W = 2;
endpackage

// File: rtl/ws_sync.sv
module ws_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= d_i;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ws_filter.sv
module ws_filter
  import ws_pkg::*;
#(
  parameter int unsigned CNT_W = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sample_i,
  input  logic      en_i,
  input  trip_pol_e pol_i,
  input  logic      filt_en_i,
  input  logic      clk_run_i,
  output logic      trip_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             active;
  logic [CNT_W-1:0] cnt_q;
  logic             trip_q;

  assign active = en_i && (sample_i == logic'(pol_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (!filt_en_i) begin
      cnt_q  <= '0;
      trip_q <= active;
    end else if (!active || !clk_run_i) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (cnt_q == CNT_MAX) begin
      trip_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      trip_q <= 1'b0;
    end
  end

  assign trip_o = trip_q;

  assert_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !trip_o);

  assert_clk_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && !clk_run_i) |=> !trip_o);

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_en_i && !active) |=> (cnt_q == '0));

  assert_full_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(trip_o) && $past(filt_en_i)) |-> ($past(cnt_q) == CNT_MAX));
endmodule

// File: rtl/ws_route.sv
module ws_route #(
  parameter int unsigned NUM_OUT = 6,
  parameter int unsigned NUM_PG  = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trip_i,
  input  logic               route_en_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               gate_en_i,
  input  logic [NUM_OUT-1:0] safe_i,
  input  logic [NUM_OUT-1:0] wave_i,
  input  logic [NUM_PG-1:0]  pg_i,
  output logic [NUM_OUT-1:0] pin_o,
  output logic [NUM_PG-1:0]  gate_o
);
  localparam logic [NUM_PG-1:0] ONE = NUM_PG'(1);

  logic              pg_sel;
  logic [NUM_PG-1:0] gate_q;

  assign pg_sel = pg_i[sel_i];

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_pin
    always_comb begin
      if (trip_i)          pin_o[i] = safe_i[i];
      else if (route_en_i) pin_o[i] = pg_sel;
      else                 pin_o[i] = wave_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gate_q <= '0;
    else if (gate_en_i) gate_q <= ONE << sel_i;
    else                gate_q <= '0;
  end

  assign gate_o = gate_q;

  assert_gate_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gate_o));

  assert_gate_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_en_i |=> gate_o[$past(sel_i)]);

  assert_gate_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_en_i |=> (gate_o == '0));
endmodule

// File: rtl/wave_shutdown.sv
module wave_shutdown
  import ws_pkg::*;
#(
  parameter int unsigned NUM_OUT     = DEF_OUTS,
  parameter int unsigned NUM_PG      = DEF_PGS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC,
  parameter int unsigned FILT_W      = DEF_FILT_W,
  localparam int unsigned SEL_W      = (NUM_PG > 1) ? $clog2(NUM_PG) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trip_en_i,
  input  logic               trip_pol_i,
  input  logic               filt_en_i,
  input  logic               clk_run_i,
  input  logic               route_en_i,
  input  logic [SEL_W-1:0]   route_sel_i,
  input  logic               gate_en_i,
  input  logic [NUM_OUT-1:0] safe_lvl_i,
  input  logic [NUM_OUT-1:0] wave_i,
  input  logic [NUM_PG-1:0]  pg_i,
  input  logic               trip_pin_i,
  output logic [NUM_OUT-1:0] pin_o,
  output logic               trip_o,
  output logic [NUM_PG-1:0]  gate_o
);
  logic pin_sync;
  logic trip;

  ws_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (trip_pin_i),
    .q_o    (pin_sync)
  );

  ws_filter #(.CNT_W(FILT_W)) u_filter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (pin_sync),
    .en_i      (trip_en_i),
    .pol_i     (trip_pol_e'(trip_pol_i)),
    .filt_en_i (filt_en_i),
    .clk_run_i (clk_run_i),
    .trip_o    (trip)
  );

  ws_route #(.NUM_OUT(NUM_OUT), .NUM_PG(NUM_PG), .SEL_W(SEL_W)) u_route (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trip_i     (trip),
    .route_en_i (route_en_i),
    .sel_i      (route_sel_i),
    .gate_en_i  (gate_en_i),
    .safe_i     (safe_lvl_i),
    .wave_i     (wave_i),
    .pg_i       (pg_i),
    .pin_o      (pin_o),
    .gate_o     (gate_o)
  );

  assign trip_o = trip;

  assert_safe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> (pin_o == safe_lvl_i));
endmodule

// File: tb/wave_shutdown_test.sv
`timescale 1ns/1ps
module wave_shutdown_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 0, pol = 0, filt = 0, run = 1, ren = 0, gen = 0;
  logic [1:0] sel = 0;
  logic [5:0] safe = 0, wave = 0;
  logic [3:0] pg = 0;
  logic       tpin = 1;
  logic [5:0] pin_o;
  logic       trip_o;
  logic [3:0] gate_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wave_shutdown uut (
    .clk_i(clk), .rst_ni(rst_n), .trip_en_i(en), .trip_pol_i(pol),
    .filt_en_i(filt), .clk_run_i(run), .route_en_i(ren), .route_sel_i(sel),
    .gate_en_i(gen), .safe_lvl_i(safe), .wave_i(wave), .pg_i(pg),
    .trip_pin_i(tpin), .pin_o(pin_o), .trip_o(trip_o), .gate_o(gate_o)
  );

  // reference: two sample delays, then count consecutive qualified samples
  logic       m_s1, m_s2, exp_trip;
  int         run_len;
  logic [3:0] exp_gate;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; exp_trip <= 0; run_len <= 0; exp_gate <= 0;
    end else begin
      automatic logic act = en && (m_s2 == pol);
      automatic int nr = (filt && act && run) ? ((run_len < 7) ? run_len + 1 : 7) : 0;
      m_s1 <= tpin;
      m_s2 <= m_s1;
      run_len <= nr;
      exp_trip <= filt ? (nr >= 4) : act;
      exp_gate <= gen ? (4'b0001 << sel) : 4'b0000;
    end
  end

  function automatic logic [5:0] exp_pins(input logic t);
    if (t) return safe;
    if (ren) return {6{pg[sel]}};
    return wave;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_model(input string tt);
    chk(trip_o == exp_trip, tt, {7'd0, trip_o}, {7'd0, exp_trip});
    chk(pin_o == exp_pins(exp_trip), ren ? "R9 route" : "R8 pins",
        {2'd0, pin_o}, {2'd0, exp_pins(exp_trip)});
    chk(gate_o == exp_gate, "R10 gate", {4'd0, gate_o}, {4'd0, exp_gate});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed_sink;
    seed_sink = $urandom(32'h1a2b3c);
    wave = 6'h2d; safe = 6'h15;
    step(3);
    // R1 reset state
    chk(trip_o == 0, "R1 trip", {7'd0, trip_o}, 8'd0);
    chk(gate_o == 0, "R1 gate", {4'd0, gate_o}, 8'd0);
    chk(pin_o == wave, "R1 pins", {2'd0, pin_o}, {2'd0, wave});
    rst_n = 1;
    step(3);
    chk(trip_o == 0 && pin_o == wave, "R1 after reset", {7'd0, trip_o}, 8'd0);

    // R2 disabled: pin toggles both ways
    en = 0;
    for (int i = 0; i < 10; i++) begin
      tpin = i[1]; pol = i[2];
      step(1);
      chk(trip_o == 0 && pin_o == wave, "R2 disabled", {2'd0, pin_o}, {2'd0, wave});
    end

    // R4 unfiltered, active high
    en = 1; pol = 1; filt = 0; tpin = 0;
    step(4);
    tpin = 1;
    step(2);
    chk(trip_o == 0, "R4 early", {7'd0, trip_o}, 8'd0);
    step(1);
    chk(trip_o == 1, "R4 assert edge3", {7'd0, trip_o}, 8'd1);
    chk(pin_o == safe, "R8 forced", {2'd0, pin_o}, {2'd0, safe});
    tpin = 0;
    step(2);
    chk(trip_o == 1, "R4 still set", {7'd0, trip_o}, 8'd1);
    step(1);
    chk(trip_o == 0, "R4 release edge3", {7'd0, trip_o}, 8'd0);
    chk(pin_o == wave, "R8 released", {2'd0, pin_o}, {2'd0, wave});

    // R3 active low
    pol = 0; tpin = 1;
    step(4);
    chk(trip_o == 0, "R3 high inactive", {7'd0, trip_o}, 8'd0);
    tpin = 0;
    step(3);
    chk(trip_o == 1, "R3 low active", {7'd0, trip_o}, 8'd1);
    tpin = 1;
    step(3);
    chk(trip_o == 0, "R3 release", {7'd0, trip_o}, 8'd0);

    // R5 filtered latency
    pol = 1; filt = 1; tpin = 0;
    step(4);
    tpin = 1;
    for (int i = 1; i <= 5; i++) begin
      step(1);
      chk(trip_o == 0, "R5 before accept", {7'd0, trip_o}, 8'd0);
    end
    step(1);
    chk(trip_o == 1, "R5 accept edge6", {7'd0, trip_o}, 8'd1);
    tpin = 0;
    step(4);

    // R6 3-cycle pulses, 1-cycle gaps
    for (int i = 0; i < 16; i++) begin
      tpin = (i % 4) != 3;
      step(1);
      chk(trip_o == 0, "R6 restart", {7'd0, trip_o}, 8'd0);
    end
    tpin = 0;
    step(4);

    // R7 clock stopped
    run = 0; tpin = 1;
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk(trip_o == 0, "R7 clock stop", {7'd0, trip_o}, 8'd0);
    end
    run = 1;
    step(3);
    chk(trip_o == 0, "R7 recount", {7'd0, trip_o}, 8'd0);
    step(1);
    chk(trip_o == 1, "R7 accept edge4", {7'd0, trip_o}, 8'd1);
    run = 0;
    step(1);
    chk(trip_o == 0, "R7 stop clears", {7'd0, trip_o}, 8'd0);
    run = 1; tpin = 0; filt = 0;
    step(4);

    // R9 routing sweep
    ren = 1;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      pg = 4'b0001 << s;
      step(1);
      chk(pin_o == 6'h3f, "R9 route one", {2'd0, pin_o}, 8'h3f);
      pg = ~(4'b0001 << s);
      step(1);
      chk(pin_o == 6'h00, "R9 route zero", {2'd0, pin_o}, 8'h00);
    end
    ren = 0;

    // R10 gate
    gen = 1; sel = 2;
    step(1);
    chk(gate_o == 4'b0100, "R10 gate on", {4'd0, gate_o}, 8'h04);
    sel = 1;
    step(1);
    chk(gate_o == 4'b0010, "R10 gate follows", {4'd0, gate_o}, 8'h02);
    gen = 0;
    step(1);
    chk(gate_o == 0, "R10 gate off", {4'd0, gate_o}, 8'h00);

    // random phase against model
    for (int c = 0; c < 4000; c++) begin
      chk_model(filt ? "R5 filtered trip" : "R4 plain trip");
      if ($urandom_range(15) == 0) tpin = ~tpin;
      if ($urandom_range(63) == 0) en = $urandom_range(7) != 0;
      if ($urandom_range(63) == 0) pol = $urandom_range(1);
      if ($urandom_range(63) == 0) filt = $urandom_range(1);
      run = $urandom_range(31) != 0;
      if ($urandom_range(7) == 0) begin
        sel = 2'($urandom_range(3));
        ren = $urandom_range(1);
        gen = $urandom_range(1);
      end
      wave = 6'($urandom); pg = 4'($urandom); safe = 6'($urandom);
      step(1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule